// File: doc/BRIEF.md
# Core-local timer and software interrupt unit

This unit gives one processor core its machine timer and software interrupt sources. It holds a 64-bit time counter, a 64-bit compare threshold and a single software-interrupt flag. Each pulse on `tick` advances the time counter. A cycle counter advances with it and is driven straight out of the block. The timer-interrupt line is high whenever the threshold is at or below the current time, using an unsigned comparison.

Software reaches the three registers over a small request/response register bus. Each request carries an offset, a size code, a direction and write data. The unit answers one cycle later with ready, read data and a fault flag. Only exact, aligned accesses of the allowed size are served. Any other access faults and changes no state.

A wait-for-interrupt request lets an idle core skip ahead. If time is still below the threshold, both counters are loaded with the threshold value. The timer interrupt then fires on the next cycle.

Top module: `core_timer_intr`

## Requirements
- R1: After reset the time and cycle counters and the software flag are 0, the compare register holds all ones, `mtip_o` and `msip_o` are low and `rsp_ready` is low.
- R2: `rsp_ready` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise.
- R3: The software flag sits at offset 0x0000 and accepts size codes 2 (4 bytes) and 3 (8 bytes). A write sets the flag to bit 0 of `req_wdata`, which drives `msip_o`. A read returns the flag zero-extended.
- R4: The compare register sits at offset 0x4000 and accepts only size code 3. It can be written and read back in full.
- R5: The time counter sits at offset 0xBFF8. An 8-byte read returns the time before that cycle's update. Any write to it faults and leaves time unchanged.
- R6: A `tick` pulse that causes no wait-for-interrupt jump adds one to both the time and cycle counters, wrapping modulo 2^64.
- R7: `mtip_o` is high exactly when compare <= time, unsigned. It reflects every tick, jump and compare write from the next cycle on.
- R8: When `wfi_req` is high and time < compare, both counters take the compare value and `tick` is ignored in that cycle. When time >= compare, `wfi_req` has no effect.
- R9: A read or write at any other offset, or with a size code the register does not accept, returns `rsp_fault` high and `rsp_rdata` 0. It changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (16) | Register offset |
| req_size | input | 2 | Access size as log2 of bytes |
| req_wdata | input | TW (64) | Write data |
| rsp_ready | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | TW (64) | Read data, 0 on fault or write |
| rsp_fault | output | 1 | Access fault for the request |
| tick | input | 1 | Advance time by one |
| wfi_req | input | 1 | Wait-for-interrupt fast-forward request |
| mtip_o | output | 1 | Machine timer interrupt pending |
| msip_o | output | 1 | Machine software interrupt pending |
| cycle_o | output | TW (64) | Cycle counter |

## Verification
The bench builds the unit with its default values: a 64-bit counter width, a 16-bit offset and the three standard offsets. At that width, ticking alone could never reach the upper half of the counter range or the wrap point. The wait-for-interrupt jump can, by loading the counter with a compare value close to all ones. That brings counter wraparound within reach, along with unsigned comparisons whose top bits differ. The 16-bit offset space also lets random offsets land near the mapped registers, for example at the upper half of the compare register.

// File: rtl/htu_pkg.sv
package htu_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_SOFT = 2'd1,
    SEL_CMP  = 2'd2,
    SEL_TIME = 2'd3
  } htu_sel_e;

  localparam logic [1:0] SZ_4B = 2'd2;
  localparam logic [1:0] SZ_8B = 2'd3;
endpackage

// File: rtl/htu_decode.sv
module htu_decode
  import htu_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] SOFT_OFF = '0,
  parameter logic [AW-1:0] CMP_OFF  = AW'('h4000),
  parameter logic [AW-1:0] TIME_OFF = AW'('hBFF8)
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output htu_sel_e      sel,
  output logic          rd_ok,
  output logic          wr_ok
);
  always_comb begin
    sel = SEL_NONE;
    if (addr == SOFT_OFF && (size == SZ_4B || size == SZ_8B)) sel = SEL_SOFT;
    else if (addr == CMP_OFF && size == SZ_8B)                sel = SEL_CMP;
    else if (addr == TIME_OFF && size == SZ_8B)               sel = SEL_TIME;
  end

  assign rd_ok = (sel != SEL_NONE);
  assign wr_ok = (sel == SEL_SOFT) || (sel == SEL_CMP);
endmodule

// File: rtl/htu_counter.sv
module htu_counter #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wfi_req,
  input  logic [TW-1:0] cmp_val,
  output logic [TW-1:0] time_q,
  output logic [TW-1:0] cycle_q
);
  function automatic logic must_jump(input logic [TW-1:0] t, input logic [TW-1:0] c);
    return t < c;
  endfunction

  function automatic logic [TW-1:0] plus_one(input logic [TW-1:0] v);
    return v + {{(TW-1){1'b0}}, 1'b1};
  endfunction

  logic jump_ev;
  logic step_ev;
  assign jump_ev = wfi_req && must_jump(time_q, cmp_val);
  assign step_ev = tick && !jump_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q  <= '0;
      cycle_q <= '0;
    end else if (jump_ev) begin
      time_q  <= cmp_val;
      cycle_q <= cmp_val;
    end else if (step_ev) begin
      time_q  <= plus_one(time_q);
      cycle_q <= plus_one(cycle_q);
    end
  end

  // R6
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> (time_q == $past(time_q) + 1'b1) && (cycle_q == $past(cycle_q) + 1'b1));

  // R8
  wfi_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_ev |=> (time_q == $past(cmp_val)) && (cycle_q == $past(cmp_val)));

  // R8
  wfi_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wfi_req && !tick && (time_q >= cmp_val)) |=> $stable(time_q));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wfi_req) |=> $stable(time_q) && $stable(cycle_q));
endmodule

// File: rtl/core_timer_intr.sv
module core_timer_intr
  import htu_pkg::*;
#(
  parameter int TW = 64,
  parameter int AW = 16,
  parameter logic [AW-1:0] SOFT_OFF = '0,
  parameter logic [AW-1:0] CMP_OFF  = AW'('h4000),
  parameter logic [AW-1:0] TIME_OFF = AW'('hBFF8)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [TW-1:0] req_wdata,
  output logic          rsp_ready,
  output logic [TW-1:0] rsp_rdata,
  output logic          rsp_fault,
  input  logic          tick,
  input  logic          wfi_req,
  output logic          mtip_o,
  output logic          msip_o,
  output logic [TW-1:0] cycle_o
);
  function automatic logic timer_due(input logic [TW-1:0] c, input logic [TW-1:0] t);
    return c <= t;
  endfunction

  htu_sel_e      sel;
  logic          rd_ok, wr_ok, acc_ok;
  logic          soft_wr, cmp_wr, time_wr;
  logic [TW-1:0] cmp_q, time_q, rd_val;
  logic          msip_q;

  htu_decode #(.AW(AW), .SOFT_OFF(SOFT_OFF), .CMP_OFF(CMP_OFF), .TIME_OFF(TIME_OFF)) dec_i (
    .addr(req_addr), .size(req_size), .sel(sel), .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  htu_counter #(.TW(TW)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wfi_req(wfi_req),
    .cmp_val(cmp_q), .time_q(time_q), .cycle_q(cycle_o)
  );

  assign acc_ok  = req_write ? wr_ok : rd_ok;
  assign soft_wr = req_valid && req_write && (sel == SEL_SOFT);
  assign cmp_wr  = req_valid && req_write && (sel == SEL_CMP);
  assign time_wr = req_valid && req_write && (sel == SEL_TIME);

  always_comb begin
    case (sel)
      SEL_SOFT: rd_val = {{(TW-1){1'b0}}, msip_q};
      SEL_CMP:  rd_val = cmp_q;
      SEL_TIME: rd_val = time_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '1;
      msip_q <= 1'b0;
    end else begin
      if (cmp_wr)  cmp_q  <= req_wdata;
      if (soft_wr) msip_q <= req_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_ready <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ready <= req_valid;
      rsp_fault <= req_valid && !acc_ok;
      rsp_rdata <= (req_valid && !req_write && rd_ok) ? rd_val : '0;
    end
  end

  assign msip_o = msip_q;
  assign mtip_o = timer_due(cmp_q, time_q);

  // R2
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ready);
  // R2
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ready);
  // R9
  bad_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !acc_ok) |=> (rsp_fault && rsp_rdata == '0 && $stable(msip_o)));
  // R3
  soft_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_wr |=> (msip_o == $past(req_wdata[0])));
  // R5
  time_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |=> rsp_fault);
  // R7
  cmp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && !tick && !wfi_req) |=> (mtip_o == ($past(req_wdata) <= $past(time_q))));
endmodule

// File: tb/core_timer_intr_tb_top.sv
module core_timer_intr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        tick = 1'b0, wfi_req = 1'b0;
  logic        rsp_ready, rsp_fault, mtip_o, msip_o;
  logic [63:0] rsp_rdata, cycle_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [63:0] m_time = '0, m_cyc = '0, m_cmp = '1;
  logic        m_msip = 1'b0;

  always #2 clk = ~clk;

  core_timer_intr dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
    .tick(tick), .wfi_req(wfi_req), .mtip_o(mtip_o), .msip_o(msip_o), .cycle_o(cycle_o)
  );

  function automatic int bsel(input logic [15:0] a, input logic [1:0] s);
    if (a == 16'h0000 && (s == 2'd2 || s == 2'd3)) return 1;
    if (a == 16'h4000 && s == 2'd3) return 2;
    if (a == 16'hBFF8 && s == 2'd3) return 3;
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_cycle(input logic v, input logic w, input logic [15:0] a,
                          input logic [1:0] s, input logic [63:0] d,
                          input logic tk, input logic wf);
    int bs;
    logic ok, jump;
    logic [63:0] e_rd;
    req_valid = v; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    tick = tk; wfi_req = wf;
    bs = bsel(a, s);
    ok = w ? (bs == 1 || bs == 2) : (bs != 0);
    e_rd = '0;
    if (v && !w && ok) e_rd = (bs == 1) ? {63'd0, m_msip} : (bs == 2) ? m_cmp : m_time;
    jump = wf && (m_time < m_cmp);
    if (jump) begin m_time = m_cmp; m_cyc = m_cmp; end
    else if (tk) begin m_time = m_time + 1; m_cyc = m_cyc + 1; end
    if (v && w && ok) begin
      if (bs == 1) m_msip = d[0];
      if (bs == 2) m_cmp = d;
    end
    @(posedge clk); #1;
    chk("R2 ready", {63'd0, rsp_ready}, {63'd0, v});
    if (v) begin
      chk((w && bs == 3) ? "R5 time write fault" : "R9 fault", {63'd0, rsp_fault}, {63'd0, !ok});
      chk(bs == 1 ? "R3 read" : bs == 2 ? "R4 read" : bs == 3 ? "R5 read" : "R9 rdata", rsp_rdata, e_rd);
    end
    chk(jump ? "R8 cycle" : "R6 cycle", cycle_o, m_cyc);
    chk("R7 mtip", {63'd0, mtip_o}, {63'd0, m_cmp <= m_time});
    chk("R3 msip", {63'd0, msip_o}, {63'd0, m_msip});
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 cycle", cycle_o, 64'd0);
    chk("R1 mtip", {63'd0, mtip_o}, 64'd0);
    chk("R1 msip", {63'd0, msip_o}, 64'd0);
    chk("R1 ready", {63'd0, rsp_ready}, 64'd0);
    do_cycle(1, 0, 16'h4000, 2'd3, 0, 0, 0);
    chk("R1 cmp all ones", rsp_rdata, '1);
    do_cycle(1, 0, 16'hBFF8, 2'd3, 0, 0, 0);
    chk("R1 time zero", rsp_rdata, 64'd0);
    // R6 ticks
    repeat (3) do_cycle(0, 0, 0, 0, 0, 1, 0);
    // R3 software flag, both sizes
    do_cycle(1, 1, 16'h0000, 2'd3, 64'd1, 0, 0);
    do_cycle(1, 0, 16'h0000, 2'd2, 0, 0, 0);
    do_cycle(1, 1, 16'h0000, 2'd2, 64'hFE, 0, 0);
    do_cycle(1, 0, 16'h0000, 2'd3, 0, 0, 0);
    // R7 compare reached by ticking
    do_cycle(1, 1, 16'h4000, 2'd3, 64'd10, 0, 0);
    repeat (9) do_cycle(0, 0, 0, 0, 0, 1, 0);
    // R5 time write faults, time unchanged
    do_cycle(1, 1, 16'hBFF8, 2'd3, 64'h55, 0, 0);
    do_cycle(1, 0, 16'hBFF8, 2'd3, 0, 1, 0);
    // R9 bad sizes and offsets
    do_cycle(1, 1, 16'h4000, 2'd2, 64'd3, 0, 0);
    do_cycle(1, 0, 16'h4004, 2'd3, 0, 0, 0);
    do_cycle(1, 1, 16'h0000, 2'd1, 64'd1, 0, 0);
    do_cycle(1, 0, 16'hBFF8, 2'd2, 0, 0, 0);
    // R8 jump, then no jump when already reached
    do_cycle(1, 1, 16'h4000, 2'd3, 64'd1000, 0, 0);
    do_cycle(0, 0, 0, 0, 0, 1, 1);
    do_cycle(0, 0, 0, 0, 0, 1, 1);
    // R7 R6 wrap with unsigned compare
    do_cycle(1, 1, 16'h4000, 2'd3, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0);
    do_cycle(0, 0, 0, 0, 0, 0, 1);
    do_cycle(0, 0, 0, 0, 0, 1, 0);
    do_cycle(0, 0, 0, 0, 0, 1, 0);
    do_cycle(1, 0, 16'hBFF8, 2'd3, 0, 0, 0);
    do_cycle(1, 1, 16'h4000, 2'd3, 64'h8000_0000_0000_0000, 1, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic [1:0]  s;
      logic [63:0] d;
      case ($urandom % 6)
        0: a = 16'h0000;
        1: a = 16'h4000;
        2: a = 16'hBFF8;
        3: a = 16'h4004;
        4: a = 16'($urandom);
        default: a = 16'h4000;
      endcase
      s = ($urandom % 3 == 0) ? 2'($urandom) : 2'd3;
      d = ($urandom % 2) ? (m_time + 64'($urandom % 8) - 64'd2) : {32'($urandom), 32'($urandom)};
      do_cycle($urandom % 2 == 0, $urandom % 2 == 0, a, s, d,
               $urandom % 2 == 0, $urandom % 16 == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule